// File: doc/BRIEF.md
# Multi-thread gate schedule engine

This block runs a time-aware egress gate schedule. One shared linear table holds gate-control entries. Each entry has a duration, a destination-port bitmap, a reserve enable and a mask of traffic classes to block. Up to eight independent threads each own a contiguous slice of that table, given by a start address and an end index. A thread sits idle until the time input reaches the operational base time plus its own offset. From then on it walks its slice in a loop and keeps each entry in force for that entry's number of delta strobes.

The gate output is a per-port, per-class vector in which a set bit means the class is closed on that port. Every running thread applies the entry it is executing to the ports in that entry's bitmap. Threads that land on the same port in the same cycle have their masks combined. A configuration checker watches the end-index array, the slice bounds and the offsets of the active threads. While that checker reports an error, or while the run input is low, every thread is held idle and every gate stays open.

Top module: `gate_sched_engine`

## Requirements
- R1: Out of reset, and whenever no thread is running, `gate_closed` is all zeros, `thread_active` is all zeros and `cfg_err` is 0. Every offset resets to 1 and every start and end index resets to 0.
- R2: A thread whose number is at most `last_thread` starts in the first rising edge at which `time_now >= base_time + offset`. It becomes active one cycle later and stays active while running is allowed. A thread numbered above `last_thread` is never active.
- R3: On start, a thread executes its slice's start address. After the entry at its end index it returns to the start address, so a slice with start equal to end repeats its single entry.
- R4: An entry stays current for as many `delta_tick` pulses as its duration field holds. The thread moves to the next entry on the clock edge that samples the last of those pulses. A zero duration behaves as a duration of one.
- R5: `gate_closed[p*NUM_TC + c]` is set by a running thread whose current entry has bit p of its port bitmap set, its reserve enable at 1 and bit c of its class mask at 1. An entry whose reserve enable is 0 closes nothing.
- R6: When several running threads address the same port, that port's closed classes are the bitwise OR of their masks.
- R7: `cfg_err` is 1 when any end index is lower than the end index of the thread before it. It is also 1 when, for any thread numbered at most `last_thread`, the end index is below the start address or the offset is 0.
- R8: While `cfg_err` is 1 or `run_en` is 0, all threads return to idle on the next edge and all gates open. When both conditions clear, each thread starts again from its start address once its start time has been reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows the schedule to run |
| delta_tick | input | 1 | One-cycle strobe marking the end of a delta |
| time_now | input | TIME_W | Current time counter |
| base_time | input | TIME_W | Operational base time |
| last_thread | input | TH_W | Number of active threads minus one |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | AW | Table entry index to write |
| tbl_dur | input | DUR_W | Entry duration in deltas |
| tbl_ports | input | NUM_PORTS | Entry destination-port bitmap |
| tbl_res_en | input | 1 | Entry reserve enable |
| tbl_mask | input | NUM_TC | Entry class mask, set bit blocks the class |
| cfg_we | input | 1 | Thread configuration write strobe |
| cfg_sel | input | TH_W | Thread number to configure |
| cfg_start | input | AW | Slice start address |
| cfg_end | input | AW | Slice end index |
| cfg_offset | input | OFS_W | Start offset after the base time |
| cfg_err | output | 1 | Configuration error flag |
| thread_active | output | NUM_THREADS | One bit per running thread |
| gate_closed | output | NUM_PORTS*NUM_TC | Closed classes, NUM_TC bits per port |

## Verification
On every cycle the assertions check the following properties:
- Gates are open whenever no thread runs.
- An error or a dropped run input idles every thread on the next edge.
- A thread never starts before its offset time or above the thread limit.
- A thread always starts at its slice's start address.
- The entry pointer moves only by one step or by a wrap back to the start, and only after a delta strobe.

Whether the loop wraps at the right index and whether each entry holds for exactly its duration can only be shown by the bench's reference model. The same applies to how overlapping masks combine, to the error conditions and to restart after an error.

// File: rtl/gse_pkg.sv
package gse_pkg;

   typedef enum logic {
      PH_WAIT = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

endpackage

// File: rtl/gse_thread.sv
// One schedule thread: waits for its start time, then loops over its slice.
module gse_thread
   import gse_pkg::*;
#(
   parameter int AW    = 5,
   parameter int DUR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_ok,
   input  logic             start_hit,
   input  logic             tick,
   input  logic [AW-1:0]    slice_start,
   input  logic [AW-1:0]    slice_end,
   input  logic [DUR_W-1:0] load_dur,
   output logic             active,
   output logic [AW-1:0]    cur_ptr,
   output logic [AW-1:0]    load_ptr
);

   phase_e           ph_q;
   logic [AW-1:0]    ptr_q;
   logic [DUR_W-1:0] rem_q;

   // Index the thread will hold after its next load: slice start on entry or wrap.
   always_comb begin
      if (ph_q == PH_WAIT || ptr_q == slice_end) begin
         load_ptr = slice_start;
      end else begin
         load_ptr = ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_WAIT;
         ptr_q <= '0;
         rem_q <= '0;
      end else if (!run_ok) begin
         ph_q  <= PH_WAIT;
         ptr_q <= '0;
         rem_q <= '0;
      end else begin
         case (ph_q)
            PH_WAIT: begin
               if (start_hit) begin
                  ph_q  <= PH_RUN;
                  ptr_q <= load_ptr;
                  rem_q <= load_dur;
               end
            end
            PH_RUN: begin
               if (tick) begin
                  // zero and one both end the entry on this strobe
                  if (rem_q <= DUR_W'(1)) begin
                     ptr_q <= load_ptr;
                     rem_q <= load_dur;
                  end else begin
                     rem_q <= rem_q - 1'b1;
                  end
               end
            end
            default: ph_q <= PH_WAIT;
         endcase
      end
   end

   assign active  = (ph_q == PH_RUN);
   assign cur_ptr = ptr_q;

endmodule

// File: rtl/gse_cfg_check.sv
// Flags illegal end-index ordering, empty slices and zero offsets.
module gse_cfg_check #(
   parameter int NT    = 8,
   parameter int AW    = 5,
   parameter int OFS_W = 32,
   parameter int TH_W  = 3
) (
   input  logic [AW-1:0]    starts  [NT],
   input  logic [AW-1:0]    ends    [NT],
   input  logic [OFS_W-1:0] offsets [NT],
   input  logic [TH_W-1:0]  last_thr,
   output logic             err
);

   always_comb begin
      err = 1'b0;
      for (int i = 0; i < NT; i++) begin
         if (i > 0) begin
            if (ends[i] < ends[i-1]) err = 1'b1;
         end
         if (i <= int'(last_thr)) begin
            if (ends[i] < starts[i]) err = 1'b1;
            if (offsets[i] == '0)    err = 1'b1;
         end
      end
   end

endmodule

// File: rtl/gse_gate_merge.sv
// Combines the current entries of all running threads into per-port masks.
module gse_gate_merge #(
   parameter int NT  = 8,
   parameter int NP  = 4,
   parameter int NTC = 8
) (
   input  logic [NT-1:0]  active,
   input  logic [NP-1:0]  ports  [NT],
   input  logic           res_en [NT],
   input  logic [NTC-1:0] mask   [NT],
   output logic [NP*NTC-1:0] closed
);

   for (genvar p = 0; p < NP; p++) begin : g_port
      logic [NTC-1:0] acc;
      always_comb begin
         acc = '0;
         for (int t = 0; t < NT; t++) begin
            if (active[t] && ports[t][p] && res_en[t]) begin
               acc = acc | mask[t];
            end
         end
      end
      assign closed[p*NTC +: NTC] = acc;
   end

endmodule

// File: rtl/gate_sched_engine.sv
module gate_sched_engine
   import gse_pkg::*;
#(
   parameter  int NUM_THREADS = 8,
   parameter  int TBL_DEPTH   = 32,
   parameter  int NUM_PORTS   = 4,
   parameter  int NUM_TC      = 8,
   parameter  int DUR_W       = 16,
   parameter  int OFS_W       = 32,
   parameter  int TIME_W      = 64,
   localparam int AW          = $clog2(TBL_DEPTH),
   localparam int TH_W        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int GATE_W      = NUM_PORTS * NUM_TC
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run_en,
   input  logic                   delta_tick,
   input  logic [TIME_W-1:0]      time_now,
   input  logic [TIME_W-1:0]      base_time,
   input  logic [TH_W-1:0]        last_thread,
   input  logic                   tbl_we,
   input  logic [AW-1:0]          tbl_addr,
   input  logic [DUR_W-1:0]       tbl_dur,
   input  logic [NUM_PORTS-1:0]   tbl_ports,
   input  logic                   tbl_res_en,
   input  logic [NUM_TC-1:0]      tbl_mask,
   input  logic                   cfg_we,
   input  logic [TH_W-1:0]        cfg_sel,
   input  logic [AW-1:0]          cfg_start,
   input  logic [AW-1:0]          cfg_end,
   input  logic [OFS_W-1:0]       cfg_offset,
   output logic                   cfg_err,
   output logic [NUM_THREADS-1:0] thread_active,
   output logic [GATE_W-1:0]      gate_closed
);

   // ---- elaboration-time parameter checks ----
   if (NUM_THREADS < 1 || NUM_THREADS > 8) begin : g_bad_threads
      $error("NUM_THREADS must lie between 1 and 8");
   end
   if (TBL_DEPTH < 2 || (TBL_DEPTH & (TBL_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("TBL_DEPTH must be a power of two of at least 2");
   end
   if (OFS_W > TIME_W) begin : g_bad_ofs
      $error("OFS_W may not exceed TIME_W");
   end
   if (NUM_PORTS < 1 || NUM_TC < 1 || DUR_W < 1) begin : g_bad_widths
      $error("port, class and duration widths must be positive");
   end

   // ---- shared entry table ----
   logic [DUR_W-1:0]     ent_dur   [TBL_DEPTH];
   logic [NUM_PORTS-1:0] ent_ports [TBL_DEPTH];
   logic                 ent_res   [TBL_DEPTH];
   logic [NUM_TC-1:0]    ent_mask  [TBL_DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TBL_DEPTH; i++) begin
            ent_dur[i]   <= '0;
            ent_ports[i] <= '0;
            ent_res[i]   <= 1'b0;
            ent_mask[i]  <= '0;
         end
      end else if (tbl_we) begin
         ent_dur[tbl_addr]   <= tbl_dur;
         ent_ports[tbl_addr] <= tbl_ports;
         ent_res[tbl_addr]   <= tbl_res_en;
         ent_mask[tbl_addr]  <= tbl_mask;
      end
   end

   // ---- per-thread configuration registers ----
   logic [AW-1:0]    cfg_start_q [NUM_THREADS];
   logic [AW-1:0]    cfg_end_q   [NUM_THREADS];
   logic [OFS_W-1:0] cfg_ofs_q   [NUM_THREADS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_THREADS; i++) begin
            cfg_start_q[i] <= '0;
            cfg_end_q[i]   <= '0;
            cfg_ofs_q[i]   <= OFS_W'(1);
         end
      end else if (cfg_we && int'(cfg_sel) < NUM_THREADS) begin
         cfg_start_q[cfg_sel] <= cfg_start;
         cfg_end_q[cfg_sel]   <= cfg_end;
         cfg_ofs_q[cfg_sel]   <= cfg_offset;
      end
   end

   gse_cfg_check #(
      .NT    (NUM_THREADS),
      .AW    (AW),
      .OFS_W (OFS_W),
      .TH_W  (TH_W)
   ) u_cfg_check (
      .starts   (cfg_start_q),
      .ends     (cfg_end_q),
      .offsets  (cfg_ofs_q),
      .last_thr (last_thread),
      .err      (cfg_err)
   );

   logic run_ok;
   assign run_ok = run_en && !cfg_err;

   // ---- threads ----
   logic [AW-1:0]        th_ptr    [NUM_THREADS];
   logic [AW-1:0]        nxt_ptr   [NUM_THREADS];
   logic [NUM_PORTS-1:0] sel_ports [NUM_THREADS];
   logic                 sel_res   [NUM_THREADS];
   logic [NUM_TC-1:0]    sel_mask  [NUM_THREADS];

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic hit;
      logic en;
      assign hit = time_now >= (base_time + TIME_W'(cfg_ofs_q[t]));
      assign en  = run_ok && (t <= int'(last_thread));

      gse_thread #(
         .AW    (AW),
         .DUR_W (DUR_W)
      ) u_thr (
         .clk         (clk),
         .rst_n       (rst_n),
         .run_ok      (en),
         .start_hit   (hit),
         .tick        (delta_tick),
         .slice_start (cfg_start_q[t]),
         .slice_end   (cfg_end_q[t]),
         .load_dur    (ent_dur[nxt_ptr[t]]),
         .active      (thread_active[t]),
         .cur_ptr     (th_ptr[t]),
         .load_ptr    (nxt_ptr[t])
      );

      assign sel_ports[t] = ent_ports[th_ptr[t]];
      assign sel_res[t]   = ent_res[th_ptr[t]];
      assign sel_mask[t]  = ent_mask[th_ptr[t]];
   end

   gse_gate_merge #(
      .NT  (NUM_THREADS),
      .NP  (NUM_PORTS),
      .NTC (NUM_TC)
   ) u_merge (
      .active (thread_active),
      .ports  (sel_ports),
      .res_en (sel_res),
      .mask   (sel_mask),
      .closed (gate_closed)
   );

endmodule

// File: rtl/gate_sched_engine_chk.sv
module gate_sched_engine_chk #(
   parameter int NUM_THREADS = 8,
   parameter int AW          = 5,
   parameter int OFS_W       = 32,
   parameter int TIME_W      = 64,
   parameter int TH_W        = 3,
   parameter int GATE_W      = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   run_en,
   input logic                   cfg_err,
   input logic                   delta_tick,
   input logic [TH_W-1:0]        last_thread,
   input logic [TIME_W-1:0]      time_now,
   input logic [TIME_W-1:0]      base_time,
   input logic [NUM_THREADS-1:0] thread_active,
   input logic [GATE_W-1:0]      gate_closed,
   input logic [AW-1:0]          cur_ptr   [NUM_THREADS],
   input logic [AW-1:0]          cfg_start [NUM_THREADS],
   input logic [OFS_W-1:0]       cfg_ofs   [NUM_THREADS]
);

   assert_open_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_active == '0) |-> (gate_closed == '0));

   assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err || !run_en) |=> (thread_active == '0));

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
      assert_no_early_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(thread_active[t]) |->
            ($past(time_now) >= ($past(base_time) + TIME_W'($past(cfg_ofs[t])))));

      assert_within_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(thread_active[t]) |-> (t <= int'($past(last_thread))));

      assert_start_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(thread_active[t]) |-> (cur_ptr[t] == $past(cfg_start[t])));

      assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (thread_active[t] && $past(thread_active[t]) && !$stable(cur_ptr[t])) |->
            ((cur_ptr[t] == $past(cfg_start[t])) ||
             (cur_ptr[t] == AW'($past(cur_ptr[t]) + 1'b1))));

      assert_move_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (thread_active[t] && $past(thread_active[t]) && !$stable(cur_ptr[t])) |->
            $past(delta_tick));
   end

endmodule

bind gate_sched_engine gate_sched_engine_chk #(
   .NUM_THREADS (NUM_THREADS),
   .AW          (AW),
   .OFS_W       (OFS_W),
   .TIME_W      (TIME_W),
   .TH_W        (TH_W),
   .GATE_W      (GATE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .run_en        (run_en),
   .cfg_err       (cfg_err),
   .delta_tick    (delta_tick),
   .last_thread   (last_thread),
   .time_now      (time_now),
   .base_time     (base_time),
   .thread_active (thread_active),
   .gate_closed   (gate_closed),
   .cur_ptr       (th_ptr),
   .cfg_start     (cfg_start_q),
   .cfg_ofs       (cfg_ofs_q)
);

// File: tb/gate_sched_engine_bench.sv
`timescale 1ns/1ps
module gate_sched_engine_bench;

   localparam int NT = 8;
   localparam int DEPTH = 32;
   localparam int NP = 4;
   localparam int NTC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        delta_tick = 1'b0;
   logic [63:0] time_now = '0;
   logic [63:0] base_time = 64'd100;
   logic [2:0]  last_thread = 3'd0;
   logic        tbl_we = 1'b0;
   logic [4:0]  tbl_addr = '0;
   logic [15:0] tbl_dur = '0;
   logic [3:0]  tbl_ports = '0;
   logic        tbl_res_en = 1'b0;
   logic [7:0]  tbl_mask = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [4:0]  cfg_start = '0;
   logic [4:0]  cfg_end = '0;
   logic [31:0] cfg_offset = '0;
   logic        cfg_err;
   logic [7:0]  thread_active;
   logic [31:0] gate_closed;

   always #2.5 clk = ~clk;

   gate_sched_engine u_gate_sched_engine (
      .clk, .rst_n, .run_en, .delta_tick, .time_now, .base_time, .last_thread,
      .tbl_we, .tbl_addr, .tbl_dur, .tbl_ports, .tbl_res_en, .tbl_mask,
      .cfg_we, .cfg_sel, .cfg_start, .cfg_end, .cfg_offset,
      .cfg_err, .thread_active, .gate_closed
   );

   int total = 0;
   int bad = 0;
   bit compare_on = 1'b0;
   bit finished = 1'b0;
   string cur_req = "R1";

   // ---- reference model state ----
   int           m_dur   [DEPTH];
   logic [3:0]   m_ports [DEPTH];
   bit           m_res   [DEPTH];
   logic [7:0]   m_mask  [DEPTH];
   int           m_st    [NT];
   int           m_en    [NT];
   longint       m_of    [NT];
   bit           m_act   [NT];
   int           m_ptr   [NT];
   int           m_rem   [NT];

   function automatic bit model_err();
      bit e = 1'b0;
      for (int i = 0; i < NT; i++) begin
         if (i > 0 && m_en[i] < m_en[i-1]) e = 1'b1;
         if (i <= int'(last_thread) && (m_en[i] < m_st[i] || m_of[i] == 0)) e = 1'b1;
      end
      return e;
   endfunction

   function automatic logic [31:0] model_gate();
      logic [31:0] g = '0;
      for (int t = 0; t < NT; t++) begin
         if (m_act[t] && m_res[m_ptr[t]]) begin
            for (int p = 0; p < NP; p++) begin
               if (m_ports[m_ptr[t]][p]) g[p*NTC +: NTC] = g[p*NTC +: NTC] | m_mask[m_ptr[t]];
            end
         end
      end
      return g;
   endfunction

   function automatic logic [7:0] model_act();
      logic [7:0] a = '0;
      for (int t = 0; t < NT; t++) a[t] = m_act[t];
      return a;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            m_dur[i] = 0; m_ports[i] = '0; m_res[i] = 1'b0; m_mask[i] = '0;
         end
         for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_en[t] = 0; m_of[t] = 1;
            m_act[t] = 1'b0; m_ptr[t] = 0; m_rem[t] = 0;
         end
      end else begin
         bit err_now;
         err_now = model_err();
         for (int t = 0; t < NT; t++) begin
            if (!(run_en && !err_now && t <= int'(last_thread))) begin
               m_act[t] = 1'b0; m_ptr[t] = 0; m_rem[t] = 0;
            end else if (!m_act[t]) begin
               if (time_now >= base_time + 64'(m_of[t])) begin
                  m_act[t] = 1'b1; m_ptr[t] = m_st[t]; m_rem[t] = m_dur[m_st[t]];
               end
            end else if (delta_tick) begin
               if (m_rem[t] <= 1) begin
                  m_ptr[t] = (m_ptr[t] == m_en[t]) ? m_st[t] : m_ptr[t] + 1;
                  m_rem[t] = m_dur[m_ptr[t]];
               end else begin
                  m_rem[t] = m_rem[t] - 1;
               end
            end
         end
         if (tbl_we) begin
            m_dur[tbl_addr] = int'(tbl_dur); m_ports[tbl_addr] = tbl_ports;
            m_res[tbl_addr] = tbl_res_en;    m_mask[tbl_addr] = tbl_mask;
         end
         if (cfg_we) begin
            m_st[cfg_sel] = int'(cfg_start); m_en[cfg_sel] = int'(cfg_end);
            m_of[cfg_sel] = longint'(cfg_offset);
         end
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (compare_on && rst_n && !finished) begin
         check({cur_req, " thread_active"}, 64'(thread_active), 64'(model_act()));
         check({cur_req, " gate_closed"}, 64'(gate_closed), 64'(model_gate()));
         check({cur_req, " R7 cfg_err"}, 64'(cfg_err), 64'(model_err()));
      end
   end

   // time counter and delta strobe (every third cycle)
   initial begin
      forever begin
         @(posedge clk); #1;
         time_now   = time_now + 64'd1;
         delta_tick = (time_now % 3 == 0);
      end
   end

   task automatic wr_tbl(input int a, input int d, input logic [3:0] pm, input bit re,
                         input logic [7:0] mk);
      @(posedge clk); #1;
      tbl_we = 1'b1; tbl_addr = 5'(a); tbl_dur = 16'(d);
      tbl_ports = pm; tbl_res_en = re; tbl_mask = mk;
      @(posedge clk); #1;
      tbl_we = 1'b0;
   endtask

   task automatic wr_cfg(input int s, input int st, input int en, input int of);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_sel = 3'(s); cfg_start = 5'(st); cfg_end = 5'(en);
      cfg_offset = 32'(of);
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic run_cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      run_cycles(3);
      @(negedge clk);
      // R1: reset state
      check("R1 reset gates", 64'(gate_closed), 64'd0);
      check("R1 reset active", 64'(thread_active), 64'd0);
      check("R1 reset cfg_err", 64'(cfg_err), 64'd0);
      #1;
      rst_n = 1'b1;
      compare_on = 1'b1;

      cur_req = "R5";
      wr_tbl(0, 2, 4'b0001, 1'b1, 8'h0F);
      wr_tbl(1, 1, 4'b0001, 1'b1, 8'hF0);
      wr_tbl(2, 3, 4'b0010, 1'b0, 8'hFF);   // reserve disabled: closes nothing
      wr_tbl(3, 2, 4'b0011, 1'b1, 8'h01);
      wr_tbl(4, 0, 4'b0100, 1'b1, 8'h80);   // zero duration, R4
      wr_tbl(5, 1, 4'b1000, 1'b1, 8'h3C);
      wr_tbl(6, 2, 4'b0001, 1'b1, 8'h02);   // single-entry slice, R3
      wr_cfg(0, 0, 2, 5);
      wr_cfg(1, 3, 5, 9);
      wr_cfg(2, 6, 6, 20);
      for (int i = 3; i < NT; i++) wr_cfg(i, 0, 6, 1);
      last_thread = 3'd1;
      @(negedge clk);
      check("R1 idle before run", 64'(gate_closed), 64'd0);
      #1;

      cur_req = "R2 R3 R4 R5";
      run_en = 1'b1;
      run_cycles(150);

      cur_req = "R6 R3";
      last_thread = 3'd2;
      run_cycles(100);

      cur_req = "R8";
      run_en = 1'b0;
      run_cycles(5);
      @(negedge clk);
      check("R8 stopped gates", 64'(gate_closed), 64'd0);
      #1;
      run_en = 1'b1;
      run_cycles(40);

      cur_req = "R7";
      wr_cfg(1, 3, 1, 9);                    // end below previous end
      @(negedge clk);
      check("R7 end order", 64'(cfg_err), 64'd1);
      #1;
      run_cycles(8);
      wr_cfg(1, 3, 5, 9);
      run_cycles(30);
      wr_cfg(0, 0, 2, 0);                    // zero offset on an active thread
      @(negedge clk);
      check("R7 zero offset", 64'(cfg_err), 64'd1);
      #1;
      wr_cfg(0, 0, 2, 5);
      run_cycles(20);
      wr_cfg(1, 3, 2, 9);                    // end below own start
      @(negedge clk);
      check("R7 end below start", 64'(cfg_err), 64'd1);
      #1;
      wr_cfg(1, 3, 5, 9);
      wr_cfg(5, 0, 3, 1);                    // unused thread breaks ordering
      @(negedge clk);
      check("R7 unused thread order", 64'(cfg_err), 64'd1);
      #1;
      wr_cfg(5, 0, 6, 1);
      run_cycles(20);

      cur_req = "R2";
      last_thread = 3'd7;
      run_cycles(80);
      last_thread = 3'd0;
      run_cycles(20);

      compare_on = 1'b0;
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule